// File: doc/BRIEF.md
# Four-Line Transmit Request Scanner

This block sits between a host and four character serialisers. It owns one transmit buffer register and one ready flag, and it shares both across the lines. Each clock it looks for a line whose transmit enable is set and whose serialiser reports empty. When it finds one, it raises the ready flag in the status word and publishes that line's number next to the flag. The host reads the status word, writes the next character for the named line into the buffer register, and the block passes the character to that serialiser with a one-cycle load strobe.

The search is round-robin. It starts at the line after the one served last, so a line that is always busy cannot starve the others. Once a line has been offered, it stays offered until the host serves it or the line stops being eligible. The host therefore never loads a character into a line it did not read.

The same registers carry two more sets of outputs. The buffer register carries per-line break levels. The control register carries the modem-control bits for lines 2 and 3. A master-clear bit in the status write returns every enable, break, modem bit and the scan pointer to zero.

Top module: `txreq_scanner`

## Requirements
- R1: After reset, every output is zero: status word, control readback, interrupt, load strobes, character, break and modem outputs.
- R2: A control write stores bits 3:0 as the per-line transmit enables and bits 11:8 as the modem bits. The readback returns those two fields in the same positions. Bits 7:4 and 15:12 are ignored and always read as zero.
- R3: Status word layout: bit 15 is ready, bit 14 is the interrupt enable, bit 5 is scan enable, and bits 9:8 are the selected line. Every other bit reads zero. Ready is 1 exactly when scan is enabled and some line has its enable set and its serialiser empty. Bits 9:8 read zero while ready is 0.
- R4: When a new line is chosen, the search starts at the line after the one served last, wraps from 3 to 0, and takes the first eligible line. After reset or master clear, the search starts at line 0.
- R5: While ready is set and the selected line stays eligible, the selected line does not change, even when a line earlier in the search order becomes eligible.
- R6: A buffer write while ready is set does three things on the next cycle: it raises the load strobe of the selected line only, for exactly one cycle; it presents bits 7:0 on the character output; and it clears ready for that cycle. The search then continues from the next line.
- R7: A buffer write while ready is clear loads nothing. The character output keeps its previous value.
- R8: Every buffer write stores bits 11:8 as the break outputs, one per line, with bit 8 for line 0. Bits 15:12 are ignored.
- R9: Modem output bit 0 is DTR of line 3 (control bit 8). Bit 1 is RTS of line 3 (bit 9). Bit 2 is DTR of line 2 (bit 10). Bit 3 is RTS of line 2 (bit 11).
- R10: The interrupt is high exactly when ready is set and the interrupt enable (status bit 14) is set.
- R11: Clearing the enable of the selected line takes that line off offer on the next cycle. Ready drops unless another line is eligible.
- R12: A status write with bit 4 set clears the enables, breaks, modem bits, ready and scan pointer. It wins over a control or buffer write in the same cycle. Scan and interrupt enable take the values written with it.
- R13: A status write with bit 5 clear drops ready on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 16 | Status write data: bit 4 master clear, bit 5 scan enable, bit 14 interrupt enable |
| ctl_wr | input | 1 | Transmit control write strobe |
| ctl_wdata | input | 16 | Control data: enables in 3:0, modem bits in 11:8 |
| tbuf_wr | input | 1 | Transmit buffer write strobe |
| tbuf_wdata | input | 16 | Character in 7:0, break levels in 11:8 |
| ser_empty | input | 4 | Per-line serialiser empty flag |
| stat_word | output | 16 | Status word: ready, interrupt enable, line number, scan enable |
| ctl_rdata | output | 16 | Control register readback |
| tx_irq | output | 1 | Transmit interrupt |
| ser_load | output | 4 | One-cycle load strobe for each serialiser |
| ser_data | output | 8 | Character for the strobed serialiser |
| line_break | output | 4 | Per-line force-space level |
| modem_ctl | output | 4 | DTR/RTS for line 3 (bits 1:0) and line 2 (bits 3:2) |

## Verification
The assertions assume that `ser_empty` changes only between clock edges and is always driven to a known level. They also assume that the host's write strobes are single-cycle pulses with stable data. The hold property assumes the selected line is only moved by a serve, a clear, or a loss of eligibility. The stimulus drives every input at the falling edge, so each input is settled before the next rising edge. It keeps all inputs at defined values from time zero. It mixes directed write sequences with random strobes and random empty patterns, and it lets the bench's model decide every expected value.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int WORD_W     = 16;
  localparam int MAX_LINES  = 4;
  // status word fields
  localparam int ST_CLR     = 4;
  localparam int ST_SCAN    = 5;
  localparam int ST_LINE_LO = 8;
  localparam int ST_TIE     = 14;
  localparam int ST_RDY     = 15;
  // control word fields
  localparam int CTL_MDM_LO = 8;
  localparam int MDM_W      = 4;
  // transmit buffer fields
  localparam int TB_BRK_LO  = 8;

  typedef struct packed {
    logic              wr;
    logic [WORD_W-1:0] data;
  } host_wr_t;
endpackage

// File: rtl/txs_rst_sync.sv
module txs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] rot_idx [N];
  logic [N-1:0]  rot_req;

  // candidate order: start, start+1, ... wrapping at N
  for (genvar g = 0; g < N; g++) begin : g_rot
    logic [IW:0] raw;
    assign raw        = {1'b0, start} + (IW+1)'(g);
    assign rot_idx[g] = (raw >= (IW+1)'(N)) ? IW'(raw - (IW+1)'(N)) : IW'(raw);
    assign rot_req[g] = req[rot_idx[g]];
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot_req[k]) begin
        found = 1'b1;
        idx   = rot_idx[k];
      end
    end
  end
endmodule

// File: rtl/txs_cfg_regs.sv
module txs_cfg_regs
  import txs_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  host_wr_t             csr_w,
  input  host_wr_t             ctl_w,
  input  host_wr_t             tb_w,
  output logic                 clr,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] en_d,
  output logic                 scan_q,
  output logic                 scan_d,
  output logic                 tie_q,
  output logic [MDM_W-1:0]     mdm_q,
  output logic [NUM_LINES-1:0] brk_q
);
  logic [MDM_W-1:0]     mdm_d;
  logic [NUM_LINES-1:0] brk_d;
  logic                 tie_d;
  logic                 cfg_ce;
  logic                 unused_bits;

  assign unused_bits = ^{csr_w.data, ctl_w.data, tb_w.data};

  // next state
  always_comb begin
    clr    = csr_w.wr & csr_w.data[ST_CLR];
    cfg_ce = csr_w.wr | ctl_w.wr | tb_w.wr;
    en_d   = en_q;
    mdm_d  = mdm_q;
    brk_d  = brk_q;
    scan_d = scan_q;
    tie_d  = tie_q;
    if (csr_w.wr) begin
      scan_d = csr_w.data[ST_SCAN];
      tie_d  = csr_w.data[ST_TIE];
    end
    if (clr) begin
      en_d  = '0;
      mdm_d = '0;
      brk_d = '0;
    end else begin
      if (ctl_w.wr) begin
        en_d  = ctl_w.data[NUM_LINES-1:0];
        mdm_d = ctl_w.data[CTL_MDM_LO +: MDM_W];
      end
      if (tb_w.wr) brk_d = tb_w.data[TB_BRK_LO +: NUM_LINES];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mdm_q  <= '0;
      brk_q  <= '0;
      scan_q <= 1'b0;
      tie_q  <= 1'b0;
    end else if (cfg_ce) begin
      en_q   <= en_d;
      mdm_q  <= mdm_d;
      brk_q  <= brk_d;
      scan_q <= scan_d;
      tie_q  <= tie_d;
    end
  end

  a_r12_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (en_q == '0) && (brk_q == '0) && (mdm_q == '0));

  a_r2_enables_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_w.wr && !clr) |=> $stable(en_q));

  a_r8_break_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_w.wr && !clr) |=> $stable(brk_q));
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  parameter  int CHAR_W    = 8,
  localparam int LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 scan_d,
  input  logic [NUM_LINES-1:0] en_d,
  input  logic [NUM_LINES-1:0] ser_empty,
  input  logic                 tb_wr,
  input  logic [CHAR_W-1:0]    tb_char,
  output logic                 rdy_q,
  output logic [LW-1:0]        line_q,
  output logic [NUM_LINES-1:0] ser_load,
  output logic [CHAR_W-1:0]    ser_data
);
  logic [NUM_LINES-1:0] elig;
  logic [LW-1:0]        ptr_q, ptr_d;
  logic [LW-1:0]        line_d;
  logic                 rdy_d;
  logic [NUM_LINES-1:0] load_d;
  logic                 pick_found;
  logic [LW-1:0]        pick_idx;
  logic                 serve;
  logic                 keep;

  assign elig = en_d & ser_empty & {NUM_LINES{scan_d}};

  txs_rr_pick #(.N(NUM_LINES)) u_pick (
    .req   (elig),
    .start (ptr_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // next state
  always_comb begin
    serve  = tb_wr & rdy_q & ~clr;
    keep   = rdy_q & elig[line_q];
    rdy_d  = 1'b0;
    line_d = line_q;
    ptr_d  = ptr_q;
    load_d = '0;
    if (clr) begin
      line_d = '0;
      ptr_d  = '0;
    end else if (serve) begin
      load_d[line_q] = 1'b1;
      ptr_d = (line_q == LW'(NUM_LINES - 1)) ? '0 : line_q + LW'(1);
    end else if (keep) begin
      rdy_d = 1'b1;
    end else begin
      rdy_d = pick_found;
      if (pick_found) line_d = pick_idx;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      line_q   <= '0;
      ptr_q    <= '0;
      ser_load <= '0;
    end else begin
      rdy_q    <= rdy_d;
      line_q   <= line_d;
      ptr_q    <= ptr_d;
      ser_load <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ser_data <= '0;
    else if (serve) ser_data <= tb_char;
  end

  a_r6_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_load));

  a_r6_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|ser_load) |-> ($past(tb_wr) && $past(rdy_q)));

  a_r6_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wr && rdy_q && !clr) |=> !rdy_q);

  a_r5_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !clr && !tb_wr && elig[line_q]) |=> (rdy_q && $stable(line_q)));

  a_r7_no_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wr && !rdy_q) |=> (ser_load == '0) && $stable(ser_data));
endmodule

// File: rtl/txreq_scanner.sv
module txreq_scanner
  import txs_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  parameter  int CHAR_W    = 8,
  localparam int LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_wr,
  input  logic [WORD_W-1:0]    csr_wdata,
  input  logic                 ctl_wr,
  input  logic [WORD_W-1:0]    ctl_wdata,
  input  logic                 tbuf_wr,
  input  logic [WORD_W-1:0]    tbuf_wdata,
  input  logic [NUM_LINES-1:0] ser_empty,
  output logic [WORD_W-1:0]    stat_word,
  output logic [WORD_W-1:0]    ctl_rdata,
  output logic                 tx_irq,
  output logic [NUM_LINES-1:0] ser_load,
  output logic [CHAR_W-1:0]    ser_data,
  output logic [NUM_LINES-1:0] line_break,
  output logic [MDM_W-1:0]     modem_ctl
);
  logic                 rst_sn;
  logic                 clr;
  logic [NUM_LINES-1:0] en_q, en_d;
  logic                 scan_q, scan_d, tie_q;
  logic [MDM_W-1:0]     mdm_q;
  logic [NUM_LINES-1:0] brk_q;
  logic                 rdy;
  logic [LW-1:0]        line_q;
  host_wr_t             csr_w, ctl_w, tb_w;

  assign csr_w = '{wr: csr_wr,  data: csr_wdata};
  assign ctl_w = '{wr: ctl_wr,  data: ctl_wdata};
  assign tb_w  = '{wr: tbuf_wr, data: tbuf_wdata};

  txs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  txs_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .csr_w  (csr_w),
    .ctl_w  (ctl_w),
    .tb_w   (tb_w),
    .clr    (clr),
    .en_q   (en_q),
    .en_d   (en_d),
    .scan_q (scan_q),
    .scan_d (scan_d),
    .tie_q  (tie_q),
    .mdm_q  (mdm_q),
    .brk_q  (brk_q)
  );

  txs_sched #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_sn),
    .clr       (clr),
    .scan_d    (scan_d),
    .en_d      (en_d),
    .ser_empty (ser_empty),
    .tb_wr     (tbuf_wr),
    .tb_char   (tbuf_wdata[CHAR_W-1:0]),
    .rdy_q     (rdy),
    .line_q    (line_q),
    .ser_load  (ser_load),
    .ser_data  (ser_data)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ST_RDY]  = rdy;
    stat_word[ST_TIE]  = tie_q;
    stat_word[ST_SCAN] = scan_q;
    if (rdy) stat_word[ST_LINE_LO +: LW] = line_q;
    ctl_rdata                       = '0;
    ctl_rdata[NUM_LINES-1:0]        = en_q;
    ctl_rdata[CTL_MDM_LO +: MDM_W]  = mdm_q;
  end

  assign tx_irq     = rdy & tie_q;
  assign line_break = brk_q;
  assign modem_ctl  = mdm_q;

  a_r3_ready_line_enabled: assert property (@(posedge clk) disable iff (!rst_sn)
    rdy |-> (en_q[line_q] && scan_q));

  a_r11_disable_drops: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl_wr && rdy && !ctl_wdata[line_q] && !clr) |=> (!rdy || (line_q != $past(line_q))));

  a_r13_scan_off: assert property (@(posedge clk) disable iff (!rst_sn)
    (csr_wr && !csr_wdata[ST_SCAN]) |=> !rdy);
endmodule

// File: tb/tb_txreq_scanner.sv
module tb_txreq_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr, ctl_wr, tbuf_wr;
  logic [15:0] csr_wdata, ctl_wdata, tbuf_wdata;
  logic [3:0]  ser_empty;
  logic [15:0] stat_word, ctl_rdata;
  logic        tx_irq;
  logic [3:0]  ser_load, line_break, modem_ctl;
  logic [7:0]  ser_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txreq_scanner dut (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tbuf_wr(tbuf_wr), .tbuf_wdata(tbuf_wdata),
    .ser_empty(ser_empty),
    .stat_word(stat_word), .ctl_rdata(ctl_rdata), .tx_irq(tx_irq),
    .ser_load(ser_load), .ser_data(ser_data),
    .line_break(line_break), .modem_ctl(modem_ctl)
  );

  // behavioural reference model
  logic       m_s1, m_s2;
  logic [3:0] m_en, m_mdm, m_brk, m_load;
  logic       m_scan, m_tie, m_rdy;
  logic [7:0] m_data;
  int         m_ptr, m_line;

  task automatic model_reset();
    m_en = 0; m_mdm = 0; m_brk = 0; m_load = 0; m_scan = 0; m_tie = 0;
    m_rdy = 0; m_data = 0; m_ptr = 0; m_line = 0;
  endtask

  task automatic model_step();
    logic clr, served;
    logic [3:0] elig;
    int pick;
    clr    = csr_wr && csr_wdata[4];
    served = tbuf_wr && m_rdy && !clr;
    m_load = 0;
    if (csr_wr) begin m_scan = csr_wdata[5]; m_tie = csr_wdata[14]; end
    if (clr) begin
      m_en = 0; m_mdm = 0; m_brk = 0; m_ptr = 0; m_rdy = 0; m_line = 0;
    end else begin
      if (ctl_wr) begin m_en = ctl_wdata[3:0]; m_mdm = ctl_wdata[11:8]; end
      if (tbuf_wr) m_brk = tbuf_wdata[11:8];
      if (served) begin
        m_load = 4'b0001 << m_line;
        m_data = tbuf_wdata[7:0];
        m_ptr  = (m_line + 1) % 4;
        m_rdy  = 0;
      end else begin
        elig = m_en & ser_empty & {4{m_scan}};
        if (!(m_rdy && elig[m_line])) begin
          pick = -1;
          for (int k = 3; k >= 0; k--) if (elig[(m_ptr + k) % 4]) pick = (m_ptr + k) % 4;
          if (pick >= 0) begin m_rdy = 1; m_line = pick; end
          else m_rdy = 0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    logic was;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; model_reset();
    end else begin
      was = m_s2; m_s2 = m_s1; m_s1 = 1;
      if (!was) model_reset(); else model_step();
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    logic [15:0] exp_stat;
    if (cmp_on) begin
      exp_stat = 16'h0;
      exp_stat[15] = m_rdy;
      exp_stat[14] = m_tie;
      exp_stat[5]  = m_scan;
      if (m_rdy) exp_stat[9:8] = m_line[1:0];
      chk("R3 status word", stat_word, exp_stat);
      chk("R2 control readback", ctl_rdata, {4'h0, m_mdm, 4'h0, m_en});
      chk("R10 interrupt", {15'h0, tx_irq}, {15'h0, m_rdy & m_tie});
      chk("R6 load strobe", {12'h0, ser_load}, {12'h0, m_load});
      chk("R6 character", {8'h0, ser_data}, {8'h0, m_data});
      chk("R8 break", {12'h0, line_break}, {12'h0, m_brk});
      chk("R9 modem", {12'h0, modem_ctl}, {12'h0, m_mdm});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic wr_csr(input logic [15:0] d);
    @(negedge clk); csr_wr = 1; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask
  task automatic wr_ctl(input logic [15:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask
  task automatic wr_tbuf(input logic [15:0] d);
    @(negedge clk); tbuf_wr = 1; tbuf_wdata = d;
    @(negedge clk); tbuf_wr = 0;
  endtask
  task automatic set_empty(input logic [3:0] v);
    @(negedge clk); ser_empty = v;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; csr_wr = 0; ctl_wr = 0; tbuf_wr = 0;
    csr_wdata = 0; ctl_wdata = 0; tbuf_wdata = 0; ser_empty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", stat_word, 16'h0);
    chk("R1 control", ctl_rdata, 16'h0);
    chk("R1 outputs", {tx_irq, 3'b0, ser_load, line_break, modem_ctl}, 16'h0);
    chk("R1 character", {8'h0, ser_data}, 16'h0);
    cmp_on = 1;

    set_empty(4'hF);
    wr_csr(16'h4020);
    chk("R3 no enabled line", stat_word, 16'h4020);
    wr_ctl(16'hFFFF);
    chk("R2 ignored bits", ctl_rdata, 16'h0F0F);
    chk("R9 modem bits", {12'h0, modem_ctl}, 16'h000F);
    chk("R4 line 0 first", stat_word, 16'hC020);
    chk("R10 irq high", {15'h0, tx_irq}, 16'h1);

    wr_tbuf(16'h0041);
    chk("R6 strobe line 0", {12'h0, ser_load}, 16'h0001);
    chk("R6 char", {8'h0, ser_data}, 16'h0041);
    chk("R6 ready gap", stat_word, 16'h4020);
    @(negedge clk);
    chk("R4 next line 1", stat_word, 16'hC120);
    chk("R6 strobe one cycle", {12'h0, ser_load}, 16'h0);
    wr_tbuf(16'h0042);
    chk("R6 strobe line 1", {12'h0, ser_load}, 16'h0002);
    @(negedge clk);
    chk("R4 next line 2", stat_word, 16'hC220);

    set_empty(4'h0);
    chk("R3 nothing empty", stat_word, 16'h4020);
    set_empty(4'b1000);
    chk("R4 wrap search", stat_word, 16'hC320);
    set_empty(4'b1100);
    chk("R5 selection held", stat_word, 16'hC320);
    set_empty(4'b0100);
    chk("R5 reselect", stat_word, 16'hC220);

    wr_ctl(16'h0F0B);
    chk("R11 disable drops", stat_word, 16'h4020);
    wr_ctl(16'h0F0F);
    chk("R11 re-enable", stat_word, 16'hC220);

    set_empty(4'h0);
    wr_tbuf(16'h0355);
    chk("R7 no load", {12'h0, ser_load}, 16'h0);
    chk("R7 char kept", {8'h0, ser_data}, 16'h0042);
    chk("R8 break set", {12'h0, line_break}, 16'h0003);
    wr_tbuf(16'hF000);
    chk("R8 break cleared", {12'h0, line_break}, 16'h0);

    set_empty(4'hF);
    chk("R3 ready again", stat_word, 16'hC220);
    wr_csr(16'h4000);
    chk("R13 scan off", stat_word, 16'h4000);
    chk("R10 irq low", {15'h0, tx_irq}, 16'h0);
    wr_csr(16'h0020);
    chk("R10 no irq without enable", {15'h0, tx_irq}, 16'h0);
    chk("R3 scan on", stat_word, 16'h8220);

    wr_tbuf(16'h0F00);
    chk("R8 break all", {12'h0, line_break}, 16'h000F);
    @(negedge clk);
    chk("R4 line 3", stat_word, 16'h8320);
    @(negedge clk);
    csr_wr = 1; csr_wdata = 16'h0030; ctl_wr = 1; ctl_wdata = 16'h0F0F;
    @(negedge clk);
    csr_wr = 0; ctl_wr = 0;
    chk("R12 clear status", stat_word, 16'h0020);
    chk("R12 clear wins", ctl_rdata, 16'h0);
    chk("R12 break zero", {12'h0, line_break, modem_ctl}, 16'h0);
    wr_ctl(16'h000F);
    chk("R12 pointer zero", stat_word, 16'h8020);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ctl_wr     = ($urandom % 12) == 0;
      ctl_wdata  = 16'($urandom);
      csr_wr     = ($urandom % 40) == 0;
      csr_wdata  = 16'($urandom) | 16'h0020;
      if (($urandom % 4) != 0) csr_wdata[4] = 1'b0;
      tbuf_wr    = ($urandom % 3) == 0;
      tbuf_wdata = 16'($urandom);
      ser_empty  = 4'($urandom);
    end
    @(negedge clk);
    csr_wr = 0; ctl_wr = 0; tbuf_wr = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule